// File: doc/BRIEF.md
# I2C Slave Byte Shifter with Wait Release

This block is the byte-level data path of an I2C slave. It watches the open-drain SCL and SDA lines and recognises start and stop conditions. It collects the first byte after a start and compares its upper seven bits with a programmable local address. When the address matches, it acknowledges the byte and then either receives bytes from the master or sends bytes to it. The least significant bit of the address byte selects the direction.

After every byte and its acknowledge clock, the block stretches SCL low and raises an interrupt. Software works with one 8-bit data register for both directions. It reads a received byte from it, or writes the next byte to send into it. A write to the data register during the stretch loads the register and releases SCL. In receive direction, a dummy write releases the stretch.

The register bus carries a write strobe, a read strobe, a one-bit register select, write data and read data.

Top module: `i2c_byte_port`

## Requirements
- R1: After reset, the data register and the address register both read 00h, SCL and SDA are released (sclOutLow = 0, sdaOutLow = 0), and irq, errFlag and startSeen are 0.
- R2: startSeen goes to 1 after SDA falls while SCL is high (start). It returns to 0 after SDA rises while SCL is high (stop). While startSeen is 0, irq and sclOutLow stay 0.
- R3: The first byte after a start is compared in bits [7:1] with the 7-bit local address. On a match, SDA is pulled low for the ninth clock. On a mismatch, SDA stays released for the ninth clock, no wait state is entered, and the bus is ignored until the next start.
- R4: In receive direction (address byte bit 0 = 0), data bits are sampled on rising SCL, most significant bit first. Each byte is acknowledged on the ninth clock and can be read from the data register (regSel = 0) during the following wait.
- R5: After the falling edge of the ninth clock of an acknowledged byte, sclOutLow and irq stay 1 until a data-register write arrives. That write returns both to 0.
- R6: In transmit direction (address byte bit 0 = 1), the byte written during the wait is driven on SDA most significant bit first. SDA changes only while SCL is low.
- R7: In transmit direction, a NACK (SDA high on the ninth clock) ends the transfer. SDA is released, and irq and sclOutLow stay 0 until the next stop or start.
- R8: A data-register write outside the wait state leaves the register contents unchanged and sets errFlag. errFlag clears at the next start.
- R9: A write with regSel = 1 loads the local address from wrData[6:0] only while startSeen is 0. The write is ignored while startSeen is 1. The address register reads back as {0, address}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe; rdData is 0 when low |
| regSel | input | 1 | 0 selects the data register, 1 the address register |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Register read data |
| sclIn | input | 1 | SCL line level |
| sdaIn | input | 1 | SDA line level |
| sclOutLow | output | 1 | Pull SCL low (clock stretch) |
| sdaOutLow | output | 1 | Pull SDA low (acknowledge or transmit zero) |
| irq | output | 1 | Byte done, waiting for software |
| startSeen | output | 1 | A start has been seen and no stop since |
| errFlag | output | 1 | Data register written outside the wait |

## Verification
The hardest situation to reach from the ports is a data-register write that lands in the middle of a byte. A normal transaction only writes during the stretch. The bench therefore drives the eight data bits one at a time from its bus master model. It issues a register write after the fourth bit, while SCL is actively toggling. It then checks that the flag rises and that the byte finally read back is the serial byte rather than the written one. The NACK ending of a read is reached by having the master model answer the second transmitted byte with SDA high. The bench then checks that no stretch follows.

// File: rtl/i2cbs_pkg.sv
package i2cbs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_WAIT,
    ST_HOLD
  } busState_t;

  typedef struct packed {
    logic sampleBit;
    logic shiftTx;
    logic loadData;
    logic loadAddr;
    logic setErr;
    logic clrErr;
  } dpStrobe_t;
endpackage

// File: rtl/i2cbs_line_sync.sv
module i2cbs_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaS,
  output logic sclRise,
  output logic sclFall,
  output logic startEv,
  output logic stopEv
);
  logic [STAGES-1:0] sclPipe, sdaPipe;
  logic sclD, sdaD, sclS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclD    <= 1'b1;
      sdaD    <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[STAGES-2:0], sdaIn};
      sclD    <= sclS;
      sdaD    <= sdaS;
    end
  end

  assign sclS    = sclPipe[STAGES-1];
  assign sdaS    = sdaPipe[STAGES-1];
  assign sclRise = sclS && !sclD;
  assign sclFall = !sclS && sclD;
  assign startEv = sclS && sclD && sdaD && !sdaS;
  assign stopEv  = sclS && sclD && !sdaD && sdaS;
endmodule

// File: rtl/i2cbs_datapath.sv
module i2cbs_datapath
  import i2cbs_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpStrobe_t     strobe,
  input  logic          sdaS,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] shiftQ,
  output logic [AW-1:0] addrQ,
  output logic          errFlag,
  output logic          addrMatch,
  output logic          rwBit,
  output logic          txBit
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ  <= '0;
      addrQ   <= '0;
      errFlag <= 1'b0;
    end else begin
      if (strobe.loadData)       shiftQ <= wrData;
      else if (strobe.sampleBit) shiftQ <= {shiftQ[DW-2:0], sdaS};
      else if (strobe.shiftTx)   shiftQ <= {shiftQ[DW-2:0], 1'b0};

      if (strobe.loadAddr) addrQ <= wrData[AW-1:0];

      if (strobe.setErr)      errFlag <= 1'b1;
      else if (strobe.clrErr) errFlag <= 1'b0;
    end
  end

  assign addrMatch = (shiftQ[DW-1 -: AW] == addrQ);
  assign rwBit     = shiftQ[0];
  assign txBit     = shiftQ[DW-1];
endmodule

// File: rtl/i2cbs_control.sv
module i2cbs_control
  import i2cbs_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclRise,
  input  logic      sclFall,
  input  logic      startEv,
  input  logic      stopEv,
  input  logic      sdaS,
  input  logic      wrEn,
  input  logic      regSel,
  input  logic      addrMatch,
  input  logic      rwBit,
  input  logic      txBit,
  output dpStrobe_t strobe,
  output logic      sclHold,
  output logic      sdaDrive,
  output logic      irq,
  output logic      startSeen
);
  localparam int CW = $clog2(DW + 2);
  localparam logic [CW-1:0] LAST_BIT = CW'(DW);
  localparam logic [CW-1:0] ACK_CLK  = CW'(DW + 1);

  busState_t     state;
  logic [CW-1:0] bitCnt;
  logic          ackDrive, txDrive, txMode, nackSeen;
  logic          dataWr, addrWr;

  assign dataWr = wrEn && !regSel;
  assign addrWr = wrEn && regSel;

  always_comb begin
    strobe           = '0;
    strobe.loadAddr  = addrWr && !startSeen;
    strobe.loadData  = dataWr && (state == ST_WAIT);
    strobe.setErr    = dataWr && (state != ST_WAIT);
    strobe.clrErr    = startEv;
    strobe.sampleBit = sclRise && (bitCnt < LAST_BIT) &&
                       ((state == ST_ADDR) || ((state == ST_DATA) && !txMode));
    strobe.shiftTx   = sclFall && (state == ST_DATA) && txMode &&
                       (bitCnt != '0) && (bitCnt < LAST_BIT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      ackDrive  <= 1'b0;
      txDrive   <= 1'b0;
      txMode    <= 1'b0;
      nackSeen  <= 1'b0;
      startSeen <= 1'b0;
    end else if (startEv) begin
      state     <= ST_ADDR;
      bitCnt    <= '0;
      ackDrive  <= 1'b0;
      txDrive   <= 1'b0;
      txMode    <= 1'b0;
      nackSeen  <= 1'b0;
      startSeen <= 1'b1;
    end else if (stopEv) begin
      state     <= ST_IDLE;
      ackDrive  <= 1'b0;
      txDrive   <= 1'b0;
      startSeen <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_DATA: begin
          if (sclRise && bitCnt < ACK_CLK) begin
            if (bitCnt == LAST_BIT) nackSeen <= sdaS;
            bitCnt <= bitCnt + 1'b1;
          end else if (sclFall) begin
            if (bitCnt == LAST_BIT) begin
              if (state == ST_ADDR) begin
                if (addrMatch) begin
                  ackDrive <= 1'b1;
                  txMode   <= rwBit;
                end else begin
                  state <= ST_IDLE;
                end
              end else if (txMode) begin
                txDrive <= 1'b0;
              end else begin
                ackDrive <= 1'b1;
              end
            end else if (bitCnt == ACK_CLK) begin
              ackDrive <= 1'b0;
              bitCnt   <= '0;
              state    <= (state == ST_DATA && txMode && nackSeen) ? ST_HOLD : ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (dataWr) begin
            state   <= ST_DATA;
            bitCnt  <= '0;
            txDrive <= txMode;
          end
        end
        default: ;
      endcase
    end
  end

  assign sclHold  = (state == ST_WAIT);
  assign irq      = (state == ST_WAIT);
  assign sdaDrive = ackDrive || (txDrive && !txBit);
endmodule

// File: rtl/i2c_byte_port.sv
module i2c_byte_port
  import i2cbs_pkg::*;
#(
  parameter int DW          = 8,
  parameter int AW          = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic          regSel,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdData,
  input  logic          sclIn,
  input  logic          sdaIn,
  output logic          sclOutLow,
  output logic          sdaOutLow,
  output logic          irq,
  output logic          startSeen,
  output logic          errFlag
);
  dpStrobe_t     strobe;
  logic          sdaS, sclRise, sclFall, startEv, stopEv;
  logic          addrMatch, rwBit, txBit;
  logic [DW-1:0] shiftQ;
  logic [AW-1:0] addrQ;

  i2cbs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk, .rstN, .sclIn, .sdaIn,
    .sdaS, .sclRise, .sclFall, .startEv, .stopEv
  );

  i2cbs_control #(.DW(DW)) u_ctrl (
    .clk, .rstN, .sclRise, .sclFall, .startEv, .stopEv, .sdaS,
    .wrEn, .regSel, .addrMatch, .rwBit, .txBit,
    .strobe, .sclHold(sclOutLow), .sdaDrive(sdaOutLow), .irq, .startSeen
  );

  i2cbs_datapath #(.DW(DW), .AW(AW)) u_dp (
    .clk, .rstN, .strobe, .sdaS, .wrData,
    .shiftQ, .addrQ, .errFlag, .addrMatch, .rwBit, .txBit
  );

  assign rdData = !rdEn ? '0 : (regSel ? {{(DW-AW){1'b0}}, addrQ} : shiftQ);
endmodule

// File: rtl/i2cbs_checker.sv
module i2cbs_checker #(
  parameter int AW = 7
) (
  input logic          clk,
  input logic          rstN,
  input logic          wrEn,
  input logic          regSel,
  input logic          irq,
  input logic          errFlag,
  input logic          startSeen,
  input logic          sclIn,
  input logic          sclOutLow,
  input logic          sdaOutLow,
  input logic [AW-1:0] addrQ
);
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    !startSeen |-> (!irq && !sclOutLow));

  assert_release_by_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irq) |-> $past(wrEn && !regSel));

  assert_sda_moves_scl_low_R6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOutLow) |-> !sclIn);

  assert_stray_write_flags_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !regSel && !irq) |=> errFlag);

  assert_addr_locked_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regSel && startSeen) |=> $stable(addrQ));
endmodule

bind i2c_byte_port i2cbs_checker #(.AW(AW)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .regSel(regSel), .irq(irq),
  .errFlag(errFlag), .startSeen(startSeen), .sclIn(sclIn),
  .sclOutLow(sclOutLow), .sdaOutLow(sdaOutLow), .addrQ(addrQ)
);

// File: tb/i2c_byte_port_tb.sv
`timescale 1ns/1ps
module i2c_byte_port_tb;
  localparam int H = 16;
  localparam logic [6:0] LOCAL_ADDR = 7'h5A;
  // {address byte, data byte, expected match}
  localparam logic [16:0] VEC [4] = '{
    {8'hB4, 8'h96, 1'b1},
    {8'hB6, 8'h11, 1'b0},
    {8'hB4, 8'h01, 1'b1},
    {8'h34, 8'h7E, 1'b0}
  };

  logic clk = 0, rstN = 0;
  logic wrEn = 0, rdEn = 0, regSel = 0;
  logic [7:0] wrData = 0, rdData;
  logic sclOutLow, sdaOutLow, irq, startSeen, errFlag;
  logic mScl = 0, mSda = 0;
  logic sclBus, sdaBus;
  int checks = 0, failures = 0, cycles = 0;

  always #2 clk = ~clk;
  assign sclBus = !(mScl || sclOutLow);
  assign sdaBus = !(mSda || sdaOutLow);

  i2c_byte_port u_dut (
    .clk, .rstN, .wrEn, .rdEn, .regSel, .wrData, .rdData,
    .sclIn(sclBus), .sdaIn(sdaBus), .sclOutLow, .sdaOutLow,
    .irq, .startSeen, .errFlag
  );

  always @(negedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<%0d", cycles, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cpuWrite(logic sel, logic [7:0] d);
    @(negedge clk); wrEn = 1; regSel = sel; wrData = d;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic cpuRead(logic sel, output logic [7:0] d);
    @(negedge clk); rdEn = 1; regSel = sel;
    #1 d = rdData;
    @(negedge clk); rdEn = 0;
  endtask

  task automatic sclHigh();
    mScl = 0;
    @(negedge clk);
    while (!sclBus) @(negedge clk);
  endtask

  task automatic startCond();
    mSda = 0; sclHigh(); waitClk(H);
    mSda = 1; waitClk(H);
    mScl = 1; waitClk(H);
  endtask

  task automatic stopCond();
    mSda = 1; waitClk(H);
    sclHigh(); waitClk(H);
    mSda = 0; waitClk(H);
  endtask

  task automatic sendBit(logic b);
    mSda = !b; waitClk(H);
    sclHigh(); waitClk(H);
    mScl = 1; waitClk(H);
  endtask

  task automatic readBit(output logic b);
    mSda = 0; waitClk(H);
    sclHigh(); waitClk(H / 2);
    b = sdaBus; waitClk(H / 2);
    mScl = 1; waitClk(H);
  endtask

  task automatic sendByte(logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) sendBit(d[i]);
    readBit(b);
    ack = !b;
  endtask

  task automatic recvByte(output logic [7:0] d, input logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      readBit(b);
      d[i] = b;
    end
    sendBit(!ack);
  endtask

  logic ack;
  logic [7:0] rd;

  initial begin
    waitClk(3);
    rstN = 1;
    waitClk(2);
    // R1 reset state
    cpuRead(0, rd); check("R1 data", rd, 8'h00);
    cpuRead(1, rd); check("R1 addr", rd, 8'h00);
    check("R1 scl", sclOutLow, 0);
    check("R1 sda", sdaOutLow, 0);
    check("R1 irq", irq, 0);
    check("R1 err", errFlag, 0);
    check("R1 start", startSeen, 0);

    // R9 address load while idle, then blocked after start
    cpuWrite(1, {1'b0, LOCAL_ADDR});
    cpuRead(1, rd); check("R9 load", rd, {1'b0, LOCAL_ADDR});
    startCond();
    check("R2 start seen", startSeen, 1);
    cpuWrite(1, 8'h33);
    cpuRead(1, rd); check("R9 blocked", rd, {1'b0, LOCAL_ADDR});
    stopCond();
    check("R2 stop seen", startSeen, 0);

    // table walk: single-byte writes, match and mismatch
    foreach (VEC[k]) begin
      startCond();
      sendByte(VEC[k][16:9], ack);
      check("R3 addr ack", ack, VEC[k][0]);
      waitClk(4);
      if (VEC[k][0]) begin
        check("R5 irq", irq, 1);
        check("R5 hold", sclOutLow, 1);
        cpuWrite(0, 8'h00);
        sendByte(VEC[k][8:1], ack);
        check("R4 data ack", ack, 1);
        waitClk(4);
        cpuRead(0, rd); check("R4 data", rd, VEC[k][8:1]);
        cpuWrite(0, 8'h00);
      end else begin
        check("R3 no wait", irq, 0);
        check("R3 no hold", sclOutLow, 0);
      end
      stopCond();
      check("R2 idle", startSeen, 0);
    end

    // R4/R5 multi-byte write with prolonged wait
    startCond();
    sendByte(8'hB4, ack); check("R3 ack", ack, 1);
    waitClk(40);
    check("R5 still held", sclOutLow, 1);
    cpuWrite(0, 8'h00);
    waitClk(2);
    check("R5 released", sclOutLow, 0);
    check("R5 irq off", irq, 0);
    for (int n = 0; n < 3; n++) begin
      sendByte(8'h3C + 8'(n * 37), ack);
      check("R4 ack", ack, 1);
      waitClk(4);
      cpuRead(0, rd); check("R4 multi", rd, 8'h3C + 8'(n * 37));
      cpuWrite(0, 8'h00);
    end
    stopCond();

    // R8 write during a byte
    startCond();
    sendByte(8'hB4, ack); check("R3 ack", ack, 1);
    waitClk(4);
    cpuWrite(0, 8'h00);
    for (int i = 7; i >= 4; i--) sendBit(1'(8'hA5 >> i));
    cpuWrite(0, 8'hFF);
    check("R8 err set", errFlag, 1);
    for (int i = 3; i >= 0; i--) sendBit(1'(8'hA5 >> i));
    readBit(ack);
    check("R8 ack", ack, 0);
    waitClk(4);
    cpuRead(0, rd); check("R8 ignored", rd, 8'hA5);
    cpuWrite(0, 8'h00);
    stopCond();
    check("R8 err kept", errFlag, 1);
    startCond();
    check("R8 err cleared", errFlag, 0);
    stopCond();

    // R6/R7 read transaction ending in NACK
    startCond();
    sendByte(8'hB5, ack); check("R3 read ack", ack, 1);
    waitClk(4);
    check("R5 irq read", irq, 1);
    cpuWrite(0, 8'hC3);
    recvByte(rd, 1'b1); check("R6 byte0", rd, 8'hC3);
    waitClk(4);
    check("R5 irq tx", irq, 1);
    cpuWrite(0, 8'h3C);
    recvByte(rd, 1'b0); check("R6 byte1", rd, 8'h3C);
    waitClk(4);
    check("R7 no irq", irq, 0);
    check("R7 no hold", sclOutLow, 0);
    check("R7 sda free", sdaOutLow, 0);
    stopCond();
    check("R2 stop after read", startSeen, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule